// File: doc/BRIEF.md
# Frame Sequencing State Machine

This block steps a scanning range sensor through the phases of each frame. After reset it waits in a start-up phase until the rest of the system reports that it is ready. It then sits idle until the frame-period tick arrives. The tick opens an acquisition phase, in which a completion pulse arrives once for every scan point that the data mover finishes. When the number of completed points reaches the programmed total, the block enters a housekeeping phase. That phase lasts until the second software agent reports that it is done, and the block then returns to idle.

A two-bit flag code is published for two independent consumers that share the housekeeping work. The code shows when a frame has started and when acquisition has ended. The first consumer writes the flag to say that its share is finished, which lets the second consumer take over. The second consumer then reports that all housekeeping is complete. A frame tick that arrives while housekeeping is still running is not acted on. Instead it sets a sticky overrun indication that software can inspect.

Top module: `frame_sequencer`

## Requirements
- R1: After reset the phase output is 0 (start-up), the flag is 3 (B), and the overrun output is 0. The phase stays at 0 until init_done_i is seen, and ticks in that phase are ignored. init_done_i moves the phase to 1 (idle) on the next clock.
- R2: In phase 1 a frame_tick_i moves the phase to 2 (acquisition) on the next clock. In that same clock, next_frame_o pulses for one cycle and the flag becomes 0 (N). The point counter clears and the point target is taken from points_cfg_i.
- R3: In phase 2 every point_done_i pulse is counted. The pulse that brings the count to the target moves the phase to 3 (housekeeping), gives a one-cycle fov_done_o pulse, and sets the flag to 1 (F). Point pulses in phases 0, 1 and 3 are ignored.
- R4: A points_cfg_i value of 0 at frame start selects the default target of 4650 points.
- R5: waiting_o is 1 in phase 1 and 0 in every other phase.
- R6: stage1_done_i sets the flag to 2 (I) only in phase 3 while the flag is 1 (F). At any other time it leaves the flag unchanged.
- R7: blind_done_i returns the phase to 1 and the flag to 3 (B) only in phase 3 while the flag is 2 (I). At any other time it is ignored.
- R8: frame_tick_i in phase 3 sets overrun_o, which then stays 1 until reset, and does not change the phase. A tick in phase 2 is ignored and does not clear the point count.
- R9: next_frame_o and fov_done_o are never 1 in the same cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | System start-up complete |
| point_done_i | input | 1 | One scan point completed by the data mover |
| frame_tick_i | input | 1 | Frame-period tick from the master timing |
| stage1_done_i | input | 1 | First consumer finished its housekeeping share |
| blind_done_i | input | 1 | Second consumer finished all housekeeping |
| points_cfg_i | input | PTS_W | Points per frame, 0 selects the default |
| phase_o | output | 2 | Current phase code |
| flag_o | output | 2 | Published flag code (N=0, F=1, I=2, B=3) |
| waiting_o | output | 1 | Idle and waiting for the next frame |
| next_frame_o | output | 1 | One-cycle pulse at frame start |
| fov_done_o | output | 1 | One-cycle pulse at end of acquisition |
| overrun_o | output | 1 | Sticky: a frame tick arrived during housekeeping |

## Verification
The hardest condition to reach is the default point target. It only takes effect when the configuration input is zero at frame start, and it then needs 4650 consecutive completion pulses. The stimulus drives 4649 pulses and checks that the phase is still acquisition. One more pulse must then produce the end-of-acquisition pulse, which pins down the exact count. The rejected handover cases are also reached on purpose. Each premature flag write and completion report is applied in the phase where it must be ignored, and the flag and phase are compared in the following cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_IDLE  = 2'd1,
        PH_ACQ   = 2'd2,
        PH_BLIND = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        FL_N = 2'd0,
        FL_F = 2'd1,
        FL_I = 2'd2,
        FL_B = 2'd3
    } flag_t;

    function automatic logic tick_is_overrun(input phase_t ph, input logic tick);
        return tick && (ph == PH_BLIND);
    endfunction

endpackage

// File: rtl/fseq_point_counter.sv
module fseq_point_counter #(
    parameter int PTS_W          = 16,
    parameter int DEFAULT_POINTS = 4650
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [PTS_W-1:0] cfg_i,
    input  logic             active_i,
    input  logic             pulse_i,
    output logic             hit_o
);
    localparam logic [PTS_W-1:0] DEF_T = PTS_W'(DEFAULT_POINTS);

    logic [PTS_W-1:0] cnt_q;
    logic [PTS_W-1:0] target_q;
    logic [PTS_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign hit_o    = active_i && pulse_i && (next_cnt == {1'b0, target_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            target_q <= DEF_T;
        end else if (start_i) begin
            cnt_q    <= '0;
            target_q <= (cfg_i == '0) ? DEF_T : cfg_i;
        end else if (active_i && pulse_i) begin
            cnt_q    <= next_cnt[PTS_W-1:0];
        end
    end
endmodule

// File: rtl/fseq_phase_ctrl.sv
module fseq_phase_ctrl
    import fseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   init_done_i,
    input  logic   tick_i,
    input  logic   hit_i,
    input  logic   release_i,
    output phase_t phase_o,
    output logic   start_o,
    output logic   nf_o,
    output logic   fd_o
);
    phase_t ph_q, ph_d;

    assign start_o = (ph_q == PH_IDLE) && tick_i;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_START: if (init_done_i) ph_d = PH_IDLE;
            PH_IDLE:  if (tick_i)      ph_d = PH_ACQ;
            PH_ACQ:   if (hit_i)       ph_d = PH_BLIND;
            PH_BLIND: if (release_i)   ph_d = PH_IDLE;
            default:                   ph_d = PH_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_START;
            nf_o <= 1'b0;
            fd_o <= 1'b0;
        end else begin
            ph_q <= ph_d;
            nf_o <= start_o;
            fd_o <= hit_i;
        end
    end

    assign phase_o = ph_q;
endmodule

// File: rtl/fseq_flag_reg.sv
module fseq_flag_reg
    import fseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_i,
    input  logic   start_i,
    input  logic   hit_i,
    input  logic   stage1_i,
    input  logic   bdone_i,
    input  logic   tick_i,
    output flag_t  flag_o,
    output logic   release_o,
    output logic   overrun_o
);
    flag_t fl_q;
    logic  ovr_q;
    logic  handover;

    assign handover  = stage1_i && (phase_i == PH_BLIND) && (fl_q == FL_F);
    assign release_o = bdone_i && (phase_i == PH_BLIND) && (fl_q == FL_I);

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= FL_B;
            ovr_q <= 1'b0;
        end else begin
            if (start_i)        fl_q <= FL_N;
            else if (hit_i)     fl_q <= FL_F;
            else if (handover)  fl_q <= FL_I;
            else if (release_o) fl_q <= FL_B;
            if (tick_is_overrun(phase_i, tick_i)) ovr_q <= 1'b1;
        end
    end

    assign flag_o    = fl_q;
    assign overrun_o = ovr_q;
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import fseq_pkg::*;
#(
    parameter int PTS_W          = 16,
    parameter int DEFAULT_POINTS = 4650
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_done_i,
    input  logic             point_done_i,
    input  logic             frame_tick_i,
    input  logic             stage1_done_i,
    input  logic             blind_done_i,
    input  logic [PTS_W-1:0] points_cfg_i,
    output logic [1:0]       phase_o,
    output logic [1:0]       flag_o,
    output logic             waiting_o,
    output logic             next_frame_o,
    output logic             fov_done_o,
    output logic             overrun_o
);
    phase_t ph;
    flag_t  fl;
    logic   start, hit, release_w;

    fseq_phase_ctrl u_phase (
        .clk        (clk),
        .rst        (rst),
        .init_done_i(init_done_i),
        .tick_i     (frame_tick_i),
        .hit_i      (hit),
        .release_i  (release_w),
        .phase_o    (ph),
        .start_o    (start),
        .nf_o       (next_frame_o),
        .fd_o       (fov_done_o)
    );

    fseq_point_counter #(
        .PTS_W         (PTS_W),
        .DEFAULT_POINTS(DEFAULT_POINTS)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .cfg_i   (points_cfg_i),
        .active_i(ph == PH_ACQ),
        .pulse_i (point_done_i),
        .hit_o   (hit)
    );

    fseq_flag_reg u_flag (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (ph),
        .start_i  (start),
        .hit_i    (hit),
        .stage1_i (stage1_done_i),
        .bdone_i  (blind_done_i),
        .tick_i   (frame_tick_i),
        .flag_o   (fl),
        .release_o(release_w),
        .overrun_o(overrun_o)
    );

    assign phase_o   = ph;
    assign flag_o    = fl;
    assign waiting_o = (ph == PH_IDLE);
endmodule

// File: rtl/frame_sequencer_chk.sv
module frame_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       init_done_i,
    input logic       frame_tick_i,
    input logic       stage1_done_i,
    input logic       blind_done_i,
    input logic [1:0] phase_o,
    input logic [1:0] flag_o,
    input logic       next_frame_o,
    input logic       fov_done_o,
    input logic       overrun_o
);
    p_start_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd0 && !init_done_i) |=> (phase_o == 2'd0));

    p_frame_open_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1 && frame_tick_i) |=> (phase_o == 2'd2 && next_frame_o && flag_o == 2'd0));

    p_fov_end_r3: assert property (@(posedge clk) disable iff (rst)
        fov_done_o |-> (phase_o == 2'd3 && flag_o == 2'd1));

    p_stage1_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (stage1_done_i && phase_o != 2'd3) |=> (flag_o != 2'd2));

    p_release_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && blind_done_i && flag_o != 2'd2) |=> (phase_o == 2'd3));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);

    p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && frame_tick_i) |=> overrun_o);

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(next_frame_o && fov_done_o));

    p_nf_single_r9: assert property (@(posedge clk) disable iff (rst)
        next_frame_o |=> !next_frame_o);

    p_fd_single_r9: assert property (@(posedge clk) disable iff (rst)
        fov_done_o |=> !fov_done_o);
endmodule

bind frame_sequencer frame_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .init_done_i  (init_done_i),
    .frame_tick_i (frame_tick_i),
    .stage1_done_i(stage1_done_i),
    .blind_done_i (blind_done_i),
    .phase_o      (phase_o),
    .flag_o       (flag_o),
    .next_frame_o (next_frame_o),
    .fov_done_o   (fov_done_o),
    .overrun_o    (overrun_o)
);

// File: tb/frame_sequencer_test.sv
module frame_sequencer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_d = 0, pt = 0, tick = 0, s1 = 0, bd = 0;
    logic [15:0] cfg = '0;
    logic [1:0] phase, flag;
    logic wt, nf, fd, ovr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [1:0] st;
        logic [1:0] fl;
        logic       nf;
        logic       fd;
        logic       ov;
        logic       wt;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    frame_sequencer uut (
        .clk(clk), .rst(rst), .init_done_i(init_d), .point_done_i(pt),
        .frame_tick_i(tick), .stage1_done_i(s1), .blind_done_i(bd),
        .points_cfg_i(cfg), .phase_o(phase), .flag_o(flag), .waiting_o(wt),
        .next_frame_o(nf), .fov_done_o(fd), .overrun_o(ovr)
    );

    task automatic push(input string tag, input logic [1:0] es, ef,
                        input logic enf, efd, eov, ewt);
        exp_t e;
        e.tag = tag; e.st = es; e.fl = ef; e.nf = enf; e.fd = efd; e.ov = eov; e.wt = ewt;
        sb.push_back(e);
    endtask

    task automatic drive(input logic a_init, a_pt, a_tick, a_s1, a_bd, input logic [15:0] a_cfg);
        @(negedge clk);
        init_d = a_init; pt = a_pt; tick = a_tick; s1 = a_s1; bd = a_bd; cfg = a_cfg;
    endtask

    // drive one cycle and expect the outputs after the next edge
    task automatic step(input logic a_init, a_pt, a_tick, a_s1, a_bd, input logic [15:0] a_cfg,
                        input string tag, input logic [1:0] es, ef,
                        input logic enf, efd, eov, ewt);
        drive(a_init, a_pt, a_tick, a_s1, a_bd, a_cfg);
        push(tag, es, ef, enf, efd, eov, ewt);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (phase !== e.st || flag !== e.fl || nf !== e.nf || fd !== e.fd ||
                    ovr !== e.ov || wt !== e.wt) begin
                    errors++;
                    $display("FAIL %s: got st=%0d fl=%0d nf=%0d fd=%0d ov=%0d wt=%0d exp st=%0d fl=%0d nf=%0d fd=%0d ov=%0d wt=%0d",
                             e.tag, phase, flag, nf, fd, ovr, wt, e.st, e.fl, e.nf, e.fd, e.ov, e.wt);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        // R1 reset state
        @(negedge clk); rst = 1;
        push("R1 reset", 2'd0, 2'd3, 0, 0, 0, 0);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        step(0,0,1,0,0,16'd0, "R1 tick in start-up", 2'd0, 2'd3, 0,0,0,0);
        step(0,1,0,0,0,16'd0, "R3 point in start-up", 2'd0, 2'd3, 0,0,0,0);
        step(1,0,0,0,0,16'd0, "R1 init done / R5 waiting", 2'd1, 2'd3, 0,0,0,1);
        step(0,1,0,0,0,16'd0, "R3 point in idle", 2'd1, 2'd3, 0,0,0,1);
        step(0,0,0,1,0,16'd0, "R6 stage1 in idle", 2'd1, 2'd3, 0,0,0,1);
        step(0,0,0,0,1,16'd0, "R7 blind done in idle", 2'd1, 2'd3, 0,0,0,1);
        // frame 1: 3 points
        step(0,0,1,0,0,16'd3, "R2 frame start", 2'd2, 2'd0, 1,0,0,0);
        step(0,1,0,0,0,16'd0, "R9 next frame single", 2'd2, 2'd0, 0,0,0,0);
        step(0,0,1,0,0,16'd0, "R8 tick in acquisition", 2'd2, 2'd0, 0,0,0,0);
        step(0,0,0,1,0,16'd0, "R6 stage1 in acquisition", 2'd2, 2'd0, 0,0,0,0);
        step(0,1,0,0,0,16'd0, "R3 second point", 2'd2, 2'd0, 0,0,0,0);
        step(0,1,0,0,0,16'd0, "R3 third point ends fov", 2'd3, 2'd1, 0,1,0,0);
        step(0,1,0,0,0,16'd0, "R9 fov single / R3 point in blind", 2'd3, 2'd1, 0,0,0,0);
        step(0,0,0,0,1,16'd0, "R7 blind done before handover", 2'd3, 2'd1, 0,0,0,0);
        step(0,0,1,0,0,16'd0, "R8 tick in blind", 2'd3, 2'd1, 0,0,1,0);
        step(0,0,0,1,0,16'd0, "R6 stage1 handover", 2'd3, 2'd2, 0,0,1,0);
        step(0,0,0,1,0,16'd0, "R6 repeated stage1", 2'd3, 2'd2, 0,0,1,0);
        step(0,0,0,0,1,16'd0, "R7 blind done releases", 2'd1, 2'd3, 0,0,1,1);
        // frame 2: 1 point, counter must have cleared
        step(0,0,1,0,0,16'd1, "R2 second frame start", 2'd2, 2'd0, 1,0,1,0);
        step(0,0,0,0,0,16'd0, "R3 idle cycle in acq", 2'd2, 2'd0, 0,0,1,0);
        step(0,1,0,0,0,16'd0, "R3 single point frame", 2'd3, 2'd1, 0,1,1,0);
        step(0,0,0,1,0,16'd0, "R6 handover frame 2", 2'd3, 2'd2, 0,0,1,0);
        step(0,0,0,0,1,16'd0, "R7 release frame 2", 2'd1, 2'd3, 0,0,1,1);
        // reset clears overrun
        @(negedge clk); rst = 1; init_d = 0; pt = 0; tick = 0; s1 = 0; bd = 0;
        push("R8 overrun cleared by reset", 2'd0, 2'd3, 0, 0, 0, 0);
        @(negedge clk); rst = 0;
        step(1,0,0,0,0,16'd0, "R1 init again", 2'd1, 2'd3, 0,0,0,1);
        // frame 3: default target
        step(0,0,1,0,0,16'd0, "R4 default frame start", 2'd2, 2'd0, 1,0,0,0);
        for (int k = 0; k < 4648; k++) drive(0,1,0,0,0,16'd0);
        step(0,1,0,0,0,16'd0, "R4 after 4649 points", 2'd2, 2'd0, 0,0,0,0);
        step(0,1,0,0,0,16'd0, "R4 point 4650 ends fov", 2'd3, 2'd1, 0,1,0,0);
        step(0,0,0,0,0,16'd0, "R5 not waiting in blind", 2'd3, 2'd1, 0,0,0,0);
        drive(0,0,0,0,0,16'd0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule